// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between a serial port's bit stream and an infrared transceiver. In the transmit direction it watches the serial output one bit cell at a time. Every cell whose bit is zero becomes one short active-high pulse on the infrared output. A cell whose bit is one leaves the output low. In the receive direction it watches the infrared input, which goes low while light is detected. Each valid pulse becomes a zero bit, one full cell long, on the recovered receive line that feeds the serial receiver.

Two pulse widths are offered. Normal mode places a pulse of three sixteenths of a bit cell in the middle of the cell. Low-power mode makes every pulse last three periods of a separate reference strobe, whatever the bit rate. Infrared operation is active only while both the port enable and the infrared enable are set. While it is active, the wired transmit pin idles at mark and the wired receive pin is ignored. While it is inactive, the wired pins pass straight through and the infrared side is muted. A test loopback feeds the inverted infrared output back into the receive decoder. Framing of the serial characters is left to the surrounding port.

Top module: `sir_codec`

## Requirements
- R1: After reset with infrared active and no input pulse, `sir_out_o` is low and `rx_bit_o` is high.
- R2: A free-running cell position counts `tick16_i` strobes 0..15. The bit for a cell is sampled from `uart_txd_i` on the strobe that moves the position from 15 to 0. In normal mode (`lp_mode_i`=0), a zero bit drives `sir_out_o` high while the position is 7, 8 or 9, which is 3 strobes long.
- R3: A cell whose sampled bit is one produces no pulse, so `sir_out_o` stays low for the whole cell.
- R4: In low-power mode (`lp_mode_i`=1), a zero bit starts a pulse on the strobe that moves the position from 6 to 7. `sir_out_o` rises in the next cycle. It falls in the cycle after the third `lp_tick_i` strobe seen while it is high.
- R5: While infrared is inactive (`uart_en_i`=0 or `sir_en_i`=0), `sir_out_o` is low, `sir_in_i` has no effect, and `rx_bit_o` equals `pin_rxd_i`.
- R6: While infrared is active, `pin_txd_o` is 1 and `pin_rxd_i` has no effect. While it is inactive, `pin_txd_o` equals `uart_txd_i`.
- R7: `sir_en_i`=1 has no effect while `uart_en_i`=0: the wired path passes through and `sir_out_o` stays low.
- R8: A high-to-low transition of the decoder input starts a candidate pulse. The pulse becomes valid at the first `lp_tick_i` strobe in a later cycle while the input is still low. `rx_bit_o` is driven low from the cycle after validation until the 16th `tick16_i` strobe counted from the start.
- R9: A candidate pulse that returns high before any `lp_tick_i` strobe is rejected, and `rx_bit_o` stays high.
- R10: With `loop_en_i`, `test_en_i` and infrared active, the decoder input is the inverse of `sir_out_o` and `sir_in_i` is ignored. With `test_en_i`=0, the decoder keeps using `sir_in_i`.
- R11: A new falling edge during an open 16-strobe window neither restarts nor extends it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16_i | input | 1 | One-cycle strobe at 16 times the bit rate |
| lp_tick_i | input | 1 | One-cycle low-power reference strobe |
| uart_en_i | input | 1 | Serial port enable |
| sir_en_i | input | 1 | Infrared mode enable |
| lp_mode_i | input | 1 | Selects low-power pulse width |
| loop_en_i | input | 1 | Loopback enable |
| test_en_i | input | 1 | Test bit that routes loopback through the infrared path |
| uart_txd_i | input | 1 | Serial transmit bit stream from the port |
| pin_rxd_i | input | 1 | Wired receive pin |
| sir_in_i | input | 1 | Infrared receiver input, low while light is detected |
| sir_out_o | output | 1 | Infrared transmitter drive, active high |
| pin_txd_o | output | 1 | Wired transmit pin |
| rx_bit_o | output | 1 | Recovered receive bit for the serial receiver |

## Verification
On every cycle, the embedded properties check that a normal-mode pulse can only begin at cell position 7. They also check that the sampled cell bit moves only at a cell boundary and that the low-power strobe count stays in range. On the receive side, they check that a valid pulse always lies inside an open window, that validation needs a strobe with the input low, that every window closes on its 16th strobe, and that disabling the block clears pulse state. Exact pulse widths, the reference-strobe pulse length, glitch rejection, loopback routing and the non-extension of a window can only be shown by the bench. It runs its behavioural model against long stimulus sequences and measures the runs on the outputs.

// File: rtl/sir_pkg.sv
package sir_pkg;
    localparam int unsigned CELL_TICKS  = 16;
    localparam int unsigned PULSE_START = 7;
    localparam int unsigned PULSE_LEN   = 3;
    localparam int unsigned LP_PERIODS  = 3;

    localparam int unsigned PH_W  = $clog2(CELL_TICKS);
    localparam int unsigned TC_W  = $clog2(CELL_TICKS + 1);
    localparam int unsigned LPC_W = (LP_PERIODS > 1) ? $clog2(LP_PERIODS) : 1;

    typedef struct packed {
        logic [PH_W-1:0]  phase;
        logic             cell_bit;
        logic             lp_busy;
        logic [LPC_W-1:0] lp_cnt;
    } enc_state_t;

    typedef struct packed {
        logic            prev_in;
        logic            track;
        logic            valid;
        logic [TC_W-1:0] tcnt;
    } dec_state_t;
endpackage

// File: rtl/sir_enc.sv
module sir_enc
    import sir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic lp_tick_i,
    input  logic active_i,
    input  logic lp_mode_i,
    input  logic txd_i,
    output logic pulse_o
);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CELL_TICKS - 1);
    localparam logic [PH_W-1:0]  PH_FIRST = PH_W'(PULSE_START);
    localparam logic [PH_W-1:0]  PH_PRE   = PH_W'(PULSE_START - 1);
    localparam logic [PH_W-1:0]  PH_END   = PH_W'(PULSE_START + PULSE_LEN);
    localparam logic [LPC_W-1:0] LPC_LAST = LPC_W'(LP_PERIODS - 1);

    enc_state_t s_d, s_q;
    logic       nrm_pulse;

    always_comb begin
        s_d = s_q;
        if (tick_i) begin
            s_d.phase = (s_q.phase == PH_LAST) ? '0 : s_q.phase + 1'b1;
            if (s_q.phase == PH_LAST) begin
                s_d.cell_bit = txd_i;
            end
        end
        if (!active_i || !lp_mode_i) begin
            s_d.lp_busy = 1'b0;
            s_d.lp_cnt  = '0;
        end else if (s_q.lp_busy) begin
            if (lp_tick_i) begin
                if (s_q.lp_cnt == LPC_LAST) begin
                    s_d.lp_busy = 1'b0;
                    s_d.lp_cnt  = '0;
                end else begin
                    s_d.lp_cnt = s_q.lp_cnt + 1'b1;
                end
            end
        end else if (tick_i && s_q.phase == PH_PRE && !s_q.cell_bit) begin
            s_d.lp_busy = 1'b1;
            s_d.lp_cnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase    <= '0;
            s_q.cell_bit <= 1'b1;
            s_q.lp_busy  <= 1'b0;
            s_q.lp_cnt   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign nrm_pulse = active_i && !lp_mode_i && !s_q.cell_bit &&
                       (s_q.phase >= PH_FIRST) && (s_q.phase < PH_END);
    assign pulse_o   = lp_mode_i ? (active_i && s_q.lp_busy) : nrm_pulse;

    AST_PULSE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(nrm_pulse) && $stable(active_i) && $stable(lp_mode_i)) |-> (s_q.phase == PH_FIRST)) // R2
        else $error("normal pulse began off position");
    AST_CELL_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != '0) |-> $stable(s_q.cell_bit)) // R2
        else $error("cell bit moved inside a cell");
    AST_LP_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lp_busy |-> (s_q.lp_cnt <= LPC_LAST)) // R4
        else $error("low-power strobe count out of range");
    AST_ENC_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !s_q.lp_busy) // R5
        else $error("low-power pulse survived disable");
endmodule

// File: rtl/sir_dec.sv
module sir_dec
    import sir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic lp_tick_i,
    input  logic active_i,
    input  logic din_i,
    output logic rx_n_o
);
    localparam logic [TC_W-1:0] TC_LAST = TC_W'(CELL_TICKS - 1);

    dec_state_t s_d, s_q;
    logic       in_low;

    assign in_low = !din_i;

    always_comb begin
        s_d         = s_q;
        s_d.prev_in = din_i;
        if (!active_i) begin
            s_d.track   = 1'b0;
            s_d.valid   = 1'b0;
            s_d.tcnt    = '0;
            s_d.prev_in = 1'b1;
        end else if (s_q.track) begin
            if (tick_i) begin
                s_d.tcnt = s_q.tcnt + 1'b1;
            end
            if (tick_i && s_q.tcnt == TC_LAST) begin
                s_d.track = 1'b0;
                s_d.valid = 1'b0;
                s_d.tcnt  = '0;
            end else if (!s_q.valid) begin
                if (!in_low) begin
                    s_d.track = 1'b0;
                    s_d.tcnt  = '0;
                end else if (lp_tick_i) begin
                    s_d.valid = 1'b1;
                end
            end
        end else if (in_low && s_q.prev_in) begin
            s_d.track = 1'b1;
            s_d.valid = 1'b0;
            s_d.tcnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.prev_in <= 1'b1;
            s_q.track   <= 1'b0;
            s_q.valid   <= 1'b0;
            s_q.tcnt    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_n_o = !s_q.valid;

    AST_VALID_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid |-> s_q.track) // R8
        else $error("valid pulse outside window");
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.valid) |-> $past(in_low && lp_tick_i)) // R9
        else $error("pulse validated without strobe");
    AST_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && s_q.track && tick_i && s_q.tcnt == TC_LAST) |=> !s_q.track) // R11
        else $error("window not closed on last strobe");
    AST_DEC_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !s_q.valid) // R5
        else $error("decoder held a bit while disabled");
endmodule

// File: rtl/sir_codec.sv
module sir_codec
    import sir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick16_i,
    input  logic lp_tick_i,
    input  logic uart_en_i,
    input  logic sir_en_i,
    input  logic lp_mode_i,
    input  logic loop_en_i,
    input  logic test_en_i,
    input  logic uart_txd_i,
    input  logic pin_rxd_i,
    input  logic sir_in_i,
    output logic sir_out_o,
    output logic pin_txd_o,
    output logic rx_bit_o
);
    logic sir_active;
    logic loop_sel;
    logic enc_pulse;
    logic dec_in;
    logic dec_rx_n;

    assign sir_active = uart_en_i && sir_en_i;
    assign loop_sel   = sir_active && loop_en_i && test_en_i;

    sir_enc u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick16_i),
        .lp_tick_i (lp_tick_i),
        .active_i  (sir_active),
        .lp_mode_i (lp_mode_i),
        .txd_i     (uart_txd_i),
        .pulse_o   (enc_pulse)
    );

    assign dec_in = loop_sel ? !enc_pulse : sir_in_i;

    sir_dec u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick16_i),
        .lp_tick_i (lp_tick_i),
        .active_i  (sir_active),
        .din_i     (dec_in),
        .rx_n_o    (dec_rx_n)
    );

    assign sir_out_o = sir_active && enc_pulse;
    assign pin_txd_o = sir_active ? 1'b1 : uart_txd_i;
    assign rx_bit_o  = sir_active ? dec_rx_n : pin_rxd_i;
endmodule

// File: tb/sir_codec_test.sv
module sir_codec_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick16 = 1'b0, lp_tick = 1'b0;
    logic uart_en = 1'b0, sir_en = 1'b0, lp_mode = 1'b0, loop_en = 1'b0, test_en = 1'b0;
    logic uart_txd = 1'b1, pin_rxd = 1'b1, sir_in = 1'b1;
    logic sir_out, pin_txd, rx_bit;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit lp_gate = 1;

    always #4 clk = ~clk;

    sir_codec uut (
        .clk(clk), .rst_n(rst_n), .tick16_i(tick16), .lp_tick_i(lp_tick),
        .uart_en_i(uart_en), .sir_en_i(sir_en), .lp_mode_i(lp_mode),
        .loop_en_i(loop_en), .test_en_i(test_en), .uart_txd_i(uart_txd),
        .pin_rxd_i(pin_rxd), .sir_in_i(sir_in), .sir_out_o(sir_out),
        .pin_txd_o(pin_txd), .rx_bit_o(rx_bit)
    );

    // strobe generator: tick16 every 4 cycles, reference every 3
    initial begin
        int n = 0;
        forever begin
            @(posedge clk);
            #2;
            tick16  = (n % 4 == 3);
            lp_tick = lp_gate && (n % 3 == 2);
            n++;
        end
    end

    // behavioural reference model
    int m_phase = 0, m_cnt = 0, m_tc = 0;
    bit m_bit = 1, m_busy = 0, m_prev = 1, m_track = 0, m_valid = 0;

    function automatic bit m_act();
        return uart_en && sir_en;
    endfunction
    function automatic bit m_sir();
        if (!m_act()) return 0;
        if (lp_mode) return m_busy;
        return !m_bit && m_phase >= 7 && m_phase <= 9;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_bit = 1; m_busy = 0; m_cnt = 0;
            m_prev = 1; m_track = 0; m_valid = 0; m_tc = 0;
        end else begin
            bit act, din, cur;
            act = m_act();
            cur = m_sir();
            din = (act && loop_en && test_en) ? !cur : sir_in;
            if (!act) begin
                m_track = 0; m_valid = 0; m_tc = 0;
            end else if (m_track) begin
                if (tick16 && m_tc == 15) begin
                    m_track = 0; m_valid = 0; m_tc = 0;
                end else begin
                    if (tick16) m_tc++;
                    if (!m_valid) begin
                        if (din) begin m_track = 0; m_tc = 0; end
                        else if (lp_tick) m_valid = 1;
                    end
                end
            end else if (!din && m_prev) begin
                m_track = 1; m_valid = 0; m_tc = 0;
            end
            m_prev = act ? din : 1'b1;
            if (!act || !lp_mode) begin
                m_busy = 0; m_cnt = 0;
            end else if (m_busy) begin
                if (lp_tick) begin
                    if (m_cnt == 2) begin m_busy = 0; m_cnt = 0; end
                    else m_cnt++;
                end
            end else if (tick16 && m_phase == 6 && !m_bit) begin
                m_busy = 1; m_cnt = 0;
            end
            if (tick16) begin
                if (m_phase == 15) begin m_phase = 0; m_bit = uart_txd; end
                else m_phase++;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (!done) begin
            chk(lp_mode ? "R4" : "R2", "sir_out", sir_out, m_sir());
            chk("R6", "pin_txd", pin_txd, m_act() ? 1 : uart_txd);
            chk("R8", "rx_bit", rx_bit, m_act() ? !m_valid : pin_rxd);
        end
    end

    // statistics over a stretch
    int sir_hi, rx_lo, sir_runs, rx_runs, run_min, run_max, cur_run;
    bit prev_sir, prev_rx;

    task automatic clr();
        sir_hi = 0; rx_lo = 0; sir_runs = 0; rx_runs = 0;
        run_min = 1000; run_max = 0; cur_run = 0;
        prev_sir = 0; prev_rx = 1;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sir_out) begin sir_hi++; cur_run++; end
            if (!sir_out && prev_sir) begin
                sir_runs++;
                if (cur_run < run_min) run_min = cur_run;
                if (cur_run > run_max) run_max = cur_run;
                cur_run = 0;
            end
            if (!rx_bit) rx_lo++;
            if (!rx_bit && prev_rx) rx_runs++;
            prev_sir = sir_out;
            prev_rx = rx_bit;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual 0 expected 1");
        finish_run();
    end

    initial begin
        clr();
        uart_en = 1; sir_en = 1; pin_rxd = 0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset sir_out", sir_out, 0);
        chk("R1", "reset rx_bit", rx_bit, 1);
        chk("R6", "reset pin_txd", pin_txd, 1);
        @(posedge clk); #1;
        rst_n = 1;

        // R7: enable without port enable
        uart_en = 0; uart_txd = 0; clr(); cyc(70);
        chk("R7", "pulse cycles with port off", sir_hi, 0);
        chk("R7", "pin_txd passthrough", pin_txd, 0);
        chk("R5", "rx follows pin", rx_bit, 0);

        // R2/R6: normal mode pulses
        uart_en = 1; clr(); cyc(200);
        chk("R2", "pulse min width", run_min, 12);
        chk("R2", "pulse max width", run_max, 12);
        chk_rng("R2", "pulse count", sir_runs, 2, 4);
        chk("R6", "pin_rxd ignored", rx_lo, 0);
        chk("R6", "pin_txd marking", pin_txd, 1);

        // R3: ones give no pulse
        uart_txd = 1; cyc(70); clr(); cyc(130);
        chk("R3", "pulse cycles for ones", sir_hi, 0);

        // R4: low-power pulses
        lp_mode = 1; uart_txd = 0; clr(); cyc(200);
        chk_rng("R4", "lp pulse min", run_min, 7, 9);
        chk_rng("R4", "lp pulse max", run_max, 7, 9);
        chk_rng("R4", "lp pulse count", sir_runs, 2, 4);
        lp_mode = 0; uart_txd = 1; cyc(70);

        // R8/R11: decode with a second edge inside the window
        clr();
        sir_in = 0; cyc(6); sir_in = 1; cyc(20);
        sir_in = 0; cyc(3); sir_in = 1; cyc(80);
        chk_rng("R8", "rx low length", rx_lo, 56, 64);
        chk("R11", "rx low runs", rx_runs, 1);

        // R9: glitch without strobe
        lp_gate = 0; clr();
        sir_in = 0; cyc(2); sir_in = 1; lp_gate = 1; cyc(80);
        chk("R9", "rx low after glitch", rx_lo, 0);

        // R10: inverted loopback
        loop_en = 1; test_en = 1; uart_txd = 0; clr(); cyc(200);
        chk_rng("R10", "loopback rx low", rx_lo, 1, 200);
        test_en = 0; uart_txd = 1; cyc(70);
        uart_txd = 0; clr(); cyc(200);
        chk("R10", "no loopback without test bit", rx_lo, 0);
        loop_en = 0;

        // R5: infrared off
        sir_en = 0; pin_rxd = 1; clr();
        sir_in = 0; cyc(10); sir_in = 1; cyc(60);
        chk("R5", "sir_out muted", sir_hi, 0);
        chk("R5", "sir_in ignored", rx_lo, 0);
        chk("R6", "pin_txd passthrough", pin_txd, 0);

        finish_run();
    end
endmodule